// File: doc/BRIEF.md
# PWM Fault Guard

This block stands between a PWM output-override stage and the output pins. It watches a small set of external fault lines. When a fault that a channel listens to becomes active, it drives that channel's complementary high/low pair to programmed safe levels and asks the channel counter to restart. Each fault line has its own active polarity, an optional glitch filter clocked by the internal PWM clock enable, and either a level-following or a latched mode. A latched fault is released by a clear strobe.

Each channel has its own fault enable mask. A channel marked as synchronous ignores its own mask and uses the mask of channel 0. The forcing path is combinational from the fault pins for unfiltered faults. A fault can therefore take over the outputs without any clock edge, and with the PWM clock enable held low. Filtered faults and latch state advance only on clock edges. The block also returns the raw level of every fault pin and the set of faults that are currently active.

Top module: `fp_fault_guard`

## Requirements
- R1: A fault is active while its pin equals its polarity bit (1 = active high, 0 = active low), and each fault's polarity is set independently.
- R2: An unfiltered fault in follow mode (latch bit 0) raises and drops its active flag and its channel forcing combinationally, with no clock edge needed and with the PWM clock enable low.
- R3: With its filter bit set, a fault is accepted only after two consecutive enabled clock edges sample it at the active level, and it is dropped only after two consecutive samples at the inactive level. Pulses that cover fewer than two sampling edges are rejected.
- R4: In latched mode (latch bit 1), an active fault stays active after its pin leaves the active level until it is cleared.
- R5: A clear strobe for a fault takes effect at a clock edge only if the fault's input is inactive at that edge. A clear given while the input is active is ignored.
- R6: The level output shows the raw pin value of each fault, with no polarity inversion and no filtering.
- R7: Channel c uses mask bits [c*NF +: NF] of the mask input, bit y enabling fault y. When its sync bit is set, it uses the bits of channel 0 instead.
- R8: A channel whose enable bit is 0 is never forced and never requests a counter reset.
- R9: A triggered channel drives its high and low outputs to its programmed fault values and holds its counter-reset request high.
- R10: An untriggered channel passes its override-stage high and low values through unchanged. Forcing takes priority over them.
- R11: Reset clears all latched faults and all filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cck_en | input | 1 | PWM internal clock enable; paces the glitch filters |
| fault_in | input | NF | Raw fault pins |
| fault_pol | input | NF | Active level per fault |
| fault_filt | input | NF | Glitch filter enable per fault |
| fault_latch | input | NF | 0 = follow input, 1 = latched until cleared |
| fault_clr | input | NF | Clear strobe per latched fault |
| ch_en | input | NCH | Channel enable |
| ch_sync | input | NCH | Channel uses channel 0's mask |
| ch_mask | input | NCH*NF | Fault enable masks, NF bits per channel |
| fv_hi | input | NCH | Forced value of each high output |
| fv_lo | input | NCH | Forced value of each low output |
| ovr_hi | input | NCH | High output from the override stage |
| ovr_lo | input | NCH | Low output from the override stage |
| pwm_hi | output | NCH | High pin drive |
| pwm_lo | output | NCH | Low pin drive |
| cnt_rst | output | NCH | Counter reset request per channel |
| fault_level | output | NF | Raw fault pin readback |
| fault_active | output | NF | Active fault status |

## Verification
The assertions check on every clock edge that:
- a triggered channel shows its fault values and an untriggered one its override values;
- disabled channels never request a reset;
- synchronous channels trigger together with channel 0;
- unfiltered follow-mode faults track their pin;
- filter state only moves on enabled edges;
- latched faults hold until a clear or a mode change.

Some behaviour cannot be seen at clock edges and needs the bench scenarios:
- the absence of any clock dependency in the unfiltered path, which the bench checks between edges and with the PWM clock enable low;
- the exact edge on which a filtered fault is accepted or dropped;
- the rejection of short pulses;
- a clear that is ignored while the input is still active.

// File: rtl/fp_pkg.sv
package fp_pkg;
  // behaviour of a fault once it has become active
  typedef enum logic {
    FLT_FOLLOW = 1'b0,
    FLT_LATCH  = 1'b1
  } flt_mode_e;
endpackage

// File: rtl/fp_fault_cell.sv
module fp_fault_cell
  import fp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cck_en,
  input  logic      pin,
  input  logic      pol,
  input  logic      filt_en,
  input  flt_mode_e mode,
  input  logic      clr,
  output logic      active
);
  logic hit_raw;
  logic smp_q;
  logic flt_q;
  logic lat_q;
  logic cur;

  assign hit_raw = (pin == pol);

  // two-sample agreement filter, paced by the PWM clock enable
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (cck_en) begin
      smp_q <= hit_raw;
      if (hit_raw == smp_q) flt_q <= hit_raw;
    end
  end

  assign cur = filt_en ? flt_q : hit_raw;

  // latch: set by an active input, released by a clear only once the input is inactive
  always_ff @(posedge clk) begin
    if (rst)                  lat_q <= 1'b0;
    else if (mode != FLT_LATCH) lat_q <= 1'b0;
    else if (cur)             lat_q <= 1'b1;
    else if (clr)             lat_q <= 1'b0;
  end

  assign active = cur | ((mode == FLT_LATCH) & lat_q);

  assert_filter_paced_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(flt_q) && !$past(rst)) |-> $past(cck_en));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == FLT_LATCH && active && !clr) |=> (mode != FLT_LATCH || active));

  assert_latch_release_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(lat_q) && !$past(rst)) |-> ($past(clr) || $past(mode) != FLT_LATCH));
endmodule

// File: rtl/fp_chan_force.sv
module fp_chan_force #(
  parameter int NF = 5
) (
  input  logic          en,
  input  logic [NF-1:0] mask,
  input  logic [NF-1:0] active,
  input  logic          fv_hi,
  input  logic          fv_lo,
  input  logic          ovr_hi,
  input  logic          ovr_lo,
  output logic          hi,
  output logic          lo,
  output logic          trig
);
  always_comb begin
    trig = en & (|(mask & active));
    hi   = trig ? fv_hi : ovr_hi;
    lo   = trig ? fv_lo : ovr_lo;
  end
endmodule

// File: rtl/fp_fault_guard.sv
module fp_fault_guard
  import fp_pkg::*;
#(
  parameter int NF  = 5,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cck_en,
  input  logic [NF-1:0]     fault_in,
  input  logic [NF-1:0]     fault_pol,
  input  logic [NF-1:0]     fault_filt,
  input  logic [NF-1:0]     fault_latch,
  input  logic [NF-1:0]     fault_clr,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    ch_sync,
  input  logic [NCH*NF-1:0] ch_mask,
  input  logic [NCH-1:0]    fv_hi,
  input  logic [NCH-1:0]    fv_lo,
  input  logic [NCH-1:0]    ovr_hi,
  input  logic [NCH-1:0]    ovr_lo,
  output logic [NCH-1:0]    pwm_hi,
  output logic [NCH-1:0]    pwm_lo,
  output logic [NCH-1:0]    cnt_rst,
  output logic [NF-1:0]     fault_level,
  output logic [NF-1:0]     fault_active
);
  localparam int MW = NCH * NF;

  assign fault_level = fault_in;

  for (genvar y = 0; y < NF; y++) begin : g_fault
    fp_fault_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .cck_en  (cck_en),
      .pin     (fault_in[y]),
      .pol     (fault_pol[y]),
      .filt_en (fault_filt[y]),
      .mode    (flt_mode_e'(fault_latch[y])),
      .clr     (fault_clr[y]),
      .active  (fault_active[y])
    );

    assert_follow_mode_R2: assert property (@(posedge clk) disable iff (rst)
      (!fault_filt[y] && !fault_latch[y]) |-> (fault_active[y] == (fault_in[y] == fault_pol[y])));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [NF-1:0] sel_mask;
    assign sel_mask = ch_sync[c] ? ch_mask[NF-1:0] : ch_mask[c*NF +: NF];

    fp_chan_force #(.NF(NF)) u_force (
      .en     (ch_en[c]),
      .mask   (sel_mask),
      .active (fault_active),
      .fv_hi  (fv_hi[c]),
      .fv_lo  (fv_lo[c]),
      .ovr_hi (ovr_hi[c]),
      .ovr_lo (ovr_lo[c]),
      .hi     (pwm_hi[c]),
      .lo     (pwm_lo[c]),
      .trig   (cnt_rst[c])
    );

    assert_forced_vals_R9: assert property (@(posedge clk) disable iff (rst)
      cnt_rst[c] |-> (pwm_hi[c] == fv_hi[c] && pwm_lo[c] == fv_lo[c]));

    assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
      !cnt_rst[c] |-> (pwm_hi[c] == ovr_hi[c] && pwm_lo[c] == ovr_lo[c]));

    assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
      !ch_en[c] |-> !cnt_rst[c]);

    assert_sync_mask_R7: assert property (@(posedge clk) disable iff (rst)
      (ch_sync[c] && ch_en[c] && ch_en[0] && !ch_sync[0]) |-> (cnt_rst[c] == cnt_rst[0]));
  end

  initial begin
    assert_mask_width: assert (MW == $bits(ch_mask));
  end
endmodule

// File: tb/test_fp_fault_guard.sv
module test_fp_fault_guard;
  localparam int NF  = 5;
  localparam int NCH = 4;

  typedef struct {
    string          tag;
    logic [NF-1:0]  act;
    logic [NCH-1:0] hi;
    logic [NCH-1:0] lo;
    logic [NCH-1:0] rs;
  } exp_t;

  logic clk = 1'b0;
  logic rst;
  logic cck_en;
  logic [NF-1:0] fault_in, fault_pol, fault_filt, fault_latch, fault_clr;
  logic [NCH-1:0] ch_en, ch_sync, fv_hi, fv_lo, ovr_hi, ovr_lo;
  logic [NCH*NF-1:0] ch_mask;
  logic [NCH-1:0] pwm_hi, pwm_lo, cnt_rst;
  logic [NF-1:0] fault_level, fault_active;

  int checks = 0;
  int errors = 0;
  exp_t sbq[$];

  always #2 clk = ~clk;

  fp_fault_guard #(.NF(NF), .NCH(NCH)) i_fp_fault_guard (
    .clk(clk), .rst(rst), .cck_en(cck_en), .fault_in(fault_in),
    .fault_pol(fault_pol), .fault_filt(fault_filt), .fault_latch(fault_latch),
    .fault_clr(fault_clr), .ch_en(ch_en), .ch_sync(ch_sync), .ch_mask(ch_mask),
    .fv_hi(fv_hi), .fv_lo(fv_lo), .ovr_hi(ovr_hi), .ovr_lo(ovr_lo),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .cnt_rst(cnt_rst),
    .fault_level(fault_level), .fault_active(fault_active)
  );

  // driver side: compute the expected pins from the requirements and queue them
  task automatic expect_now(input string tag, input logic [NF-1:0] act);
    exp_t e;
    e.tag = tag;
    e.act = act;
    for (int c = 0; c < NCH; c++) begin
      logic [NF-1:0] m;
      logic t;
      m = ch_sync[c] ? ch_mask[NF-1:0] : ch_mask[c*NF +: NF];
      t = ch_en[c] && ((m & act) != '0);
      e.rs[c] = t;
      e.hi[c] = t ? fv_hi[c] : ovr_hi[c];
      e.lo[c] = t ? fv_lo[c] : ovr_lo[c];
    end
    sbq.push_back(e);
  endtask

  task automatic check_level(input string tag, input logic [NF-1:0] exp);
    checks++;
    if (fault_level !== exp) begin
      errors++;
      $display("FAIL %s level act=%b exp=%b", tag, fault_level, exp);
    end
  endtask

  // monitor side: pop and compare against the live outputs
  initial begin
    forever begin
      exp_t e;
      wait (sbq.size() != 0);
      e = sbq.pop_front();
      checks++;
      if (fault_active !== e.act || pwm_hi !== e.hi || pwm_lo !== e.lo || cnt_rst !== e.rs) begin
        errors++;
        $display("FAIL %s act: active=%b hi=%b lo=%b rst=%b exp: active=%b hi=%b lo=%b rst=%b",
                 e.tag, fault_active, pwm_hi, pwm_lo, cnt_rst, e.act, e.hi, e.lo, e.rs);
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cck_en = 1'b1;
    fault_in = '0; fault_pol = '1; fault_filt = '0; fault_latch = '0; fault_clr = '0;
    ch_en = 4'hF; ch_sync = 4'b0100;
    ch_mask = {5'b11000, 5'b00100, 5'b00010, 5'b00001};
    fv_hi = 4'b1010; fv_lo = 4'b0101; ovr_hi = 4'b0011; ovr_lo = 4'b1100;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 expect_now("R10 R11 after reset", 5'b00000);
    check_level("R6 idle", 5'b00000);

    // unfiltered follow mode, no clock edge between drive and sample
    @(negedge clk) fault_in = 5'b00001;
    #1 expect_now("R2 R7 R9 fault0 forces ch0 and sync ch2", 5'b00001);
    check_level("R6 fault0 high", 5'b00001);
    @(negedge clk) fault_in = 5'b00000;
    #1 expect_now("R2 fault0 released", 5'b00000);

    // active-low polarity on fault 1
    @(negedge clk) begin fault_pol[1] = 1'b0; fault_in[1] = 1'b1; end
    #1 expect_now("R1 active-low idle", 5'b00000);
    check_level("R6 raw not inverted", 5'b00010);
    @(negedge clk) fault_in[1] = 1'b0;
    #1 expect_now("R1 active-low asserted", 5'b00010);
    check_level("R6 raw low", 5'b00000);

    // disabled channel
    @(negedge clk) ch_en[1] = 1'b0;
    #1 expect_now("R8 disabled ch1 not forced", 5'b00010);
    @(negedge clk) begin ch_en[1] = 1'b1; fault_pol[1] = 1'b1; end
    #1 expect_now("R1 polarity restored", 5'b00000);

    // PWM clock enable low, unfiltered fault still forces
    @(negedge clk) begin cck_en = 1'b0; fault_in[3] = 1'b1; end
    #1 expect_now("R2 no cck fault3", 5'b01000);
    repeat (3) @(negedge clk);
    #1 expect_now("R2 no cck held", 5'b01000);
    @(negedge clk) begin fault_in[3] = 1'b0; cck_en = 1'b1; fault_filt[4] = 1'b1; end
    #1 expect_now("R2 fault3 released", 5'b00000);

    // filtered fault 4: glitch inside one cycle
    @(negedge clk) fault_in[4] = 1'b1;
    #1 fault_in[4] = 1'b0;
    expect_now("R3 glitch immediate", 5'b00000);
    repeat (2) @(negedge clk);
    #1 expect_now("R3 glitch rejected", 5'b00000);

    // one sampling edge only
    @(negedge clk) fault_in[4] = 1'b1;
    @(negedge clk) fault_in[4] = 1'b0;
    #1 expect_now("R3 single sample", 5'b00000);
    @(negedge clk);
    #1 expect_now("R3 single sample rejected", 5'b00000);

    // held across two sampling edges
    @(negedge clk) fault_in[4] = 1'b1;
    #1 expect_now("R3 no edge yet", 5'b00000);
    @(negedge clk);
    #1 expect_now("R3 one edge", 5'b00000);
    @(negedge clk);
    #1 expect_now("R3 accepted after two edges", 5'b10000);
    @(negedge clk) fault_in[4] = 1'b0;
    #1 expect_now("R3 release pending", 5'b10000);
    @(negedge clk);
    #1 expect_now("R3 release one edge", 5'b10000);
    @(negedge clk);
    #1 expect_now("R3 released after two edges", 5'b00000);

    // latched fault 0
    @(negedge clk) begin fault_latch[0] = 1'b1; fault_in[0] = 1'b1; end
    #1 expect_now("R4 latched active", 5'b00001);
    @(negedge clk) fault_in[0] = 1'b0;
    #1 expect_now("R4 holds after input drops", 5'b00001);
    repeat (2) @(negedge clk);
    #1 expect_now("R4 still held", 5'b00001);
    @(negedge clk) begin fault_in[0] = 1'b1; fault_clr[0] = 1'b1; end
    #1 expect_now("R5 clear pending while active", 5'b00001);
    @(negedge clk) begin fault_clr[0] = 1'b0; fault_in[0] = 1'b0; end
    #1 expect_now("R5 clear ignored while input active", 5'b00001);
    @(negedge clk) fault_clr[0] = 1'b1;
    #1 expect_now("R5 before clearing edge", 5'b00001);
    @(negedge clk) fault_clr[0] = 1'b0;
    #1 expect_now("R5 released by clear", 5'b00000);

    // reset drops a latched fault
    @(negedge clk) fault_in[0] = 1'b1;
    @(negedge clk) fault_in[0] = 1'b0;
    #1 expect_now("R4 latched again", 5'b00001);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1 expect_now("R11 reset clears latch", 5'b00000);

    wait (sbq.size() == 0);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule